// File: doc/BRIEF.md
# Six-Channel Programmable Event Timer

This block is a register-mapped timer with six independent 32-bit up-counters. A host programs it through a single-cycle register port (write strobe, read strobe, byte address, 32-bit data). Each channel has its own control word, a tick-selection word, a read-only live count and a compare value. A channel can halt after one compare match, reload and run again on every match, or count freely with no compare at all. That last mode gives a monotonic time base.

Two tick sources arrive as single-cycle enable pulses in the block's clock domain: a fast system tick and a slow low-power tick. Each channel picks one of them and runs it through its own power-of-two prescaler. A compare match sets a sticky per-channel pending flag. A shared enable mask and a write-one-to-acknowledge register gate these flags onto one combined interrupt line.

Top module: `multi_event_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register map, word-aligned only. Offset 0x00 is the interrupt-enable mask. Offset 0x08 reads the pending flags, and writing it acknowledges them. Channel n (1..6) occupies 0x10*n: control at +0x0, tick selection at +0x4, live count at +0x8 and compare at +0xC. Bit n-1 of the mask and pending words belongs to channel n.
- R3: In the control word, bit 0 enables counting. Writing 1 to bit 1 zeroes the counter and the prescaler, and bit 1 always reads 0. While the counter is disabled, or when no divided tick arrives, the count holds.
- R4: Control bits [5:4] = 3 selects free-run. The counter advances on every divided tick, never raises a compare event and wraps from 0xFFFFFFFF to 0.
- R5: Mode 0 is one-shot. On the divided tick that takes the count to the compare value, the count stops at that value, the pending flag sets and the enable bit clears. Later ticks change nothing.
- R6: Mode 2 behaves exactly as one-shot and reads back as 2.
- R7: Mode 1 is repeat. On the divided tick that would reach the compare value, the count reloads to 0, the pending flag sets and the channel keeps running, so one event occurs every compare-value ticks.
- R8: Bit 4 of the tick-selection word picks the source: 0 selects the fast tick and 1 selects the slow tick. Pulses on the unselected source do not move the count.
- R9: Bits [3:0] of the tick-selection word hold a code k. The count advances once per 2^k selected ticks, so code 0 divides by 1, code 1 by 2 and code 2 by 4.
- R10: Pending flags are sticky. Writing 1 to bit n-1 at 0x08 clears channel n's flag, and writing 0 leaves it set. A compare event in the same cycle as its acknowledge wins, so the flag stays set.
- R11: `irq` is the OR over all channels of (pending AND enabled). A masked pending flag still reads back at 0x08.
- R12: The live count is read-only, and a write to +0x8 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_tick | input | 1 | Fast system tick enable pulse |
| slow_tick | input | 1 | Slow low-power tick enable pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take the two tick inputs and the bus strobes to be synchronous levels that are stable around each rising edge. They also take a write to a channel's control word to be the only way its enable bit can be re-armed. The prescaler check allows the divider code to change between cycles, so it makes no assumption about when software rewrites it. The bench drives every input on the falling edge and keeps each tick pulse exactly one cycle wide. It places acknowledges and tick pulses in the same cycle only in the test that deliberately aims at the event-versus-acknowledge priority.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        MODE_ONCE = 2'd0,
        MODE_LOOP = 2'd1,
        MODE_RSVD = 2'd2,
        MODE_FREE = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TSEL  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_CMP   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_CLR_BIT  = 1;
    localparam int CTRL_MODE_LSB = 4;
    localparam int TSEL_SRC_BIT  = 4;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] code_i,
    output logic             tick_o
);
    localparam int PCNT_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PCNT_W-1:0] pcnt;
    } pre_state_t;

    pre_state_t        s_d, s_q;
    logic [PCNT_W-1:0] mask;

    always_comb begin
        s_d    = s_q;
        mask   = (PCNT_W'(1) << code_i) - PCNT_W'(1);
        tick_o = run_i && tick_i && ((s_q.pcnt & mask) == mask);
        if (clear_i) begin
            s_d.pcnt = '0;
        end else if (run_i && tick_i) begin
            s_d.pcnt = s_q.pcnt + PCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: with a divider above 1, two divided ticks never fall in consecutive cycles
    assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && code_i != '0) |=> (!tick_o || code_i == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fast_tick_i,
    input  logic             slow_tick_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_tsel_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] ctrl_o,
    output logic [CNT_W-1:0] tsel_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             event_o
);
    typedef struct packed {
        logic             en;
        run_mode_e        mode;
        logic             src;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] cmp;
    } ch_state_t;

    ch_state_t        s_d, s_q;
    logic             clr;
    logic             src_tick;
    logic             div_tick;
    logic [CNT_W-1:0] nxt;

    assign clr      = wr_ctrl_i && wdata_i[CTRL_CLR_BIT];
    assign src_tick = s_q.src ? slow_tick_i : fast_tick_i;

    tmr_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clr),
        .run_i   (s_q.en),
        .tick_i  (src_tick),
        .code_i  (s_q.div),
        .tick_o  (div_tick)
    );

    always_comb begin
        s_d     = s_q;
        event_o = 1'b0;
        nxt     = s_q.count + CNT_W'(1);

        if (wr_tsel_i) begin
            s_d.src = wdata_i[TSEL_SRC_BIT];
            s_d.div = wdata_i[DIV_W-1:0];
        end
        if (wr_cmp_i) begin
            s_d.cmp = wdata_i;
        end
        if (wr_ctrl_i) begin
            s_d.en   = wdata_i[CTRL_EN_BIT];
            s_d.mode = run_mode_e'(wdata_i[CTRL_MODE_LSB +: 2]);
        end

        if (clr) begin
            s_d.count = '0;
        end else if (div_tick) begin
            if (s_q.mode == MODE_FREE) begin
                s_d.count = nxt;
            end else if (nxt == s_q.cmp) begin
                event_o = 1'b1;
                if (s_q.mode == MODE_LOOP) begin
                    s_d.count = '0;
                end else begin
                    s_d.count = nxt;
                    if (!wr_ctrl_i) s_d.en = 1'b0;
                end
            end else begin
                s_d.count = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_o                       = '0;
        ctrl_o[CTRL_EN_BIT]          = s_q.en;
        ctrl_o[CTRL_MODE_LSB +: 2]   = s_q.mode;
        tsel_o                       = '0;
        tsel_o[TSEL_SRC_BIT]         = s_q.src;
        tsel_o[DIV_W-1:0]            = s_q.div;
    end

    assign count_o = s_q.count;
    assign cmp_o   = s_q.cmp;

    // R5 / R6: a match outside repeat mode disarms the channel
    assert_oneshot_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && s_q.mode != MODE_LOOP && !wr_ctrl_i) |=> !s_q.en);

    // R7: a match in repeat mode restarts from zero
    assert_loop_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o && s_q.mode == MODE_LOOP) |=> (s_q.count == '0));

    // R4: free-run wraps from all ones to zero
    assert_free_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MODE_FREE && div_tick && !clr && s_q.count == '1) |=> (s_q.count == '0));

    // R3: without a divided tick or a clear, the count holds
    assert_count_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_tick && !clr) |=> $stable(s_q.count));

    // R3: a disabled channel receives no divided tick
    assert_idle_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.en) |-> !div_tick);

endmodule

// File: rtl/tmr_intc.sv
module tmr_intc #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_wr_i,
    input  logic              ack_wr_i,
    input  logic [NUM_CH-1:0] wmask_i,
    input  logic [NUM_CH-1:0] event_i,
    output logic [NUM_CH-1:0] ie_o,
    output logic [NUM_CH-1:0] pend_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] ie;
        logic [NUM_CH-1:0] pend;
    } intc_state_t;

    intc_state_t       s_d, s_q;
    logic [NUM_CH-1:0] ack_mask;

    always_comb begin
        s_d      = s_q;
        ack_mask = ack_wr_i ? wmask_i : '0;
        if (ie_wr_i) s_d.ie = wmask_i;
        s_d.pend = (s_q.pend & ~ack_mask) | event_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ie_o   = s_q.ie;
    assign pend_o = s_q.pend;
    assign irq_o  = |(s_q.pend & s_q.ie);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R10: an event always leaves its flag set, acknowledge or not
        assert_event_beats_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
            event_i[i] |=> pend_o[i]);
        // R10: an acknowledge without a concurrent event clears the flag
        assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_wr_i && wmask_i[i] && !event_i[i]) |=> !pend_o[i]);
        // R10: flags are sticky until acknowledged
        assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !(ack_wr_i && wmask_i[i])) |=> pend_o[i]);
    end

endmodule

// File: rtl/multi_event_timer.sv
module multi_event_timer
    import evt_timer_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 4;

    logic             aligned;
    logic [IDX_W-1:0] ch_idx;
    reg_sel_e         sel;
    logic             glb_hit;

    logic [NUM_CH-1:0] ie_q;
    logic [NUM_CH-1:0] pend_q;
    logic [NUM_CH-1:0] ch_event;
    logic [CNT_W-1:0]  ch_ctrl  [NUM_CH];
    logic [CNT_W-1:0]  ch_tsel  [NUM_CH];
    logic [CNT_W-1:0]  ch_count [NUM_CH];
    logic [CNT_W-1:0]  ch_cmp   [NUM_CH];

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign ch_idx  = bus_addr[ADDR_W-1:4];
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign glb_hit = aligned && (ch_idx == '0);

    tmr_intc #(.NUM_CH(NUM_CH)) u_intc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_wr_i  (bus_wr && glb_hit && sel == SEL_CTRL),
        .ack_wr_i (bus_wr && glb_hit && sel == SEL_COUNT),
        .wmask_i  (bus_wdata[NUM_CH-1:0]),
        .event_i  (ch_event),
        .ie_o     (ie_q),
        .pend_o   (pend_q),
        .irq_o    (irq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = bus_wr && aligned && (ch_idx == IDX_W'(i + 1));

        tmr_channel #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .fast_tick_i (fast_tick),
            .slow_tick_i (slow_tick),
            .wr_ctrl_i   (hit && sel == SEL_CTRL),
            .wr_tsel_i   (hit && sel == SEL_TSEL),
            .wr_cmp_i    (hit && sel == SEL_CMP),
            .wdata_i     (bus_wdata),
            .ctrl_o      (ch_ctrl[i]),
            .tsel_o      (ch_tsel[i]),
            .count_o     (ch_count[i]),
            .cmp_o       (ch_cmp[i]),
            .event_o     (ch_event[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned) begin
            if (ch_idx == '0) begin
                if (sel == SEL_CTRL)  bus_rdata = CNT_W'(ie_q);
                if (sel == SEL_COUNT) bus_rdata = CNT_W'(pend_q);
            end else begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (ch_idx == IDX_W'(i + 1)) begin
                        case (sel)
                            SEL_CTRL:  bus_rdata = ch_ctrl[i];
                            SEL_TSEL:  bus_rdata = ch_tsel[i];
                            SEL_COUNT: bus_rdata = ch_count[i];
                            default:   bus_rdata = ch_cmp[i];
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: tb/sim_multi_event_timer.sv
module sim_multi_event_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    multi_event_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .slow_tick (slow_tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(bit slow, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (slow) slow_tick = 1'b1; else fast_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0; fast_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1", "enable mask", v, 0);
        rd(8'h08, v); check("R1", "pending", v, 0);
        rd(8'h10, v); check("R1", "ch1 control", v, 0);
        rd(8'h18, v); check("R1", "ch1 count", v, 0);
        rd(8'h6C, v); check("R1", "ch6 compare", v, 0);
        check("R1", "irq", {31'd0, irq}, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(8'h00, 32'h01);
        wr(8'h1C, 32'd5);
        rd(8'h1C, v); check("R2", "ch1 compare readback", v, 5);
        wr(8'h10, 32'h03);
        rd(8'h10, v); check("R3", "clear bit reads 0", v, 32'h01);
        pulse(0, 4);
        rd(8'h18, v); check("R5", "count before match", v, 4);
        rd(8'h08, v); check("R5", "no pending before match", v, 0);
        pulse(0, 1);
        rd(8'h18, v); check("R5", "count at match", v, 5);
        rd(8'h08, v); check("R5", "pending at match", v, 32'h01);
        rd(8'h10, v); check("R5", "enable cleared", v, 0);
        check("R11", "irq with enabled pending", {31'd0, irq}, 1);
        pulse(0, 3);
        rd(8'h18, v); check("R5", "count frozen", v, 5);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        wr(8'h08, 32'h00);
        rd(8'h08, v); check("R10", "zero ack keeps flag", v, 32'h01);
        wr(8'h08, 32'h01);
        rd(8'h08, v); check("R10", "ack clears flag", v, 0);
        check("R11", "irq after ack", {31'd0, irq}, 0);
    endtask

    task automatic t_mode2();
        logic [31:0] v;
        wr(8'h5C, 32'd2);
        wr(8'h50, 32'h23);
        pulse(0, 2);
        rd(8'h08, v); check("R6", "mode2 pending", v & 32'h10, 32'h10);
        rd(8'h50, v); check("R6", "mode2 disarmed", v, 32'h20);
        pulse(0, 2);
        rd(8'h58, v); check("R6", "mode2 count frozen", v, 2);
    endtask

    task automatic t_repeat();
        logic [31:0] v;
        wr(8'h6C, 32'd3);
        wr(8'h60, 32'h13);
        pulse(0, 3);
        rd(8'h68, v); check("R7", "reload to 0", v, 0);
        rd(8'h08, v); check("R7", "repeat pending", v & 32'h20, 32'h20);
        pulse(0, 2);
        rd(8'h68, v); check("R7", "keeps running", v, 2);
        rd(8'h60, v); check("R7", "still enabled", v, 32'h11);
        wr(8'h08, 32'h3F);
        rd(8'h08, v); check("R10", "ack all", v, 0);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        wr(8'h2C, 32'd3);
        wr(8'h20, 32'h33);
        pulse(0, 10);
        rd(8'h28, v); check("R4", "free count", v, 10);
        rd(8'h08, v); check("R4", "no compare event", v & 32'h02, 0);
        wr(8'h28, 32'h55);
        rd(8'h28, v); check("R12", "count write ignored", v, 10);
    endtask

    task automatic t_divider();
        logic [31:0] v;
        wr(8'h34, 32'h02);
        wr(8'h30, 32'h33);
        pulse(0, 8);
        rd(8'h38, v); check("R9", "divide by 4", v, 2);
        wr(8'h34, 32'h01);
        wr(8'h30, 32'h33);
        pulse(0, 5);
        rd(8'h38, v); check("R9", "divide by 2", v, 2);
    endtask

    task automatic t_source();
        logic [31:0] v;
        wr(8'h44, 32'h10);
        rd(8'h44, v); check("R2", "ch4 tick select readback", v, 32'h10);
        wr(8'h40, 32'h33);
        pulse(0, 6);
        rd(8'h48, v); check("R8", "fast ignored on slow", v, 0);
        pulse(1, 3);
        rd(8'h48, v); check("R8", "slow ticks counted", v, 3);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        rd(8'h28, v); check("R4", "ch2 advanced", v > 10 ? 32'd1 : 32'd0, 1);
        wr(8'h20, 32'h33);
        rd(8'h28, v); check("R3", "clear zeroes count", v, 0);
        wr(8'h20, 32'h32);
        pulse(0, 3);
        rd(8'h28, v); check("R3", "disabled holds", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(8'h00, 32'h00);
        wr(8'h60, 32'h13);
        wr(8'h08, 32'h20);
        pulse(0, 3);
        rd(8'h08, v); check("R11", "masked flag readable", v & 32'h20, 32'h20);
        check("R11", "masked irq low", {31'd0, irq}, 0);
        wr(8'h00, 32'h20);
        check("R11", "unmasked irq high", {31'd0, irq}, 1);
    endtask

    task automatic t_race();
        logic [31:0] v;
        wr(8'h1C, 32'd1);
        wr(8'h10, 32'h13);
        wr(8'h08, 32'h01);
        rd(8'h08, v); check("R10", "ch1 flag clear before race", v & 32'h01, 0);
        @(negedge clk);
        fast_tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h01;
        @(negedge clk);
        fast_tick = 1'b0; bus_wr = 1'b0;
        rd(8'h08, v); check("R10", "event beats ack", v & 32'h01, 32'h01);
        wr(8'h08, 32'h01);
        rd(8'h08, v); check("R10", "plain ack after race", v & 32'h01, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_ack();
        t_mode2();
        t_repeat();
        t_freerun();
        t_divider();
        t_source();
        t_clear();
        t_mask();
        t_race();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule